// File: doc/BRIEF.md
# Display Line Latch with Polarity Routing

This block sits between the line-wide capture register of a display column driver and its resistor-ladder converters. Once a horizontal line has been shifted in, a strobe pulse copies the whole line, together with the polarity input, into a holding latch. For each output channel the block then produces what the converter needs. That is the reference bank (upper or lower), a two-bit ladder segment index, a four-bit step within that segment, and a drive enable. While the strobe is high the outputs are in high impedance, and the new levels are driven once it falls.

Adjacent channels are steered to opposite reference banks, so odd and even columns always sit on opposite sides of the common electrode. Toggling the polarity input from line to line swaps the two banks. The code-to-tap map is mirrored between the banks: code 0 is the top of the upper bank but the bottom of the lower bank. A small monitor checks the strobe timing against the shift clocking around it and pulses an error flag when a spacing rule is broken.

All inputs are synchronous to `clk`. The strobe, load and start signals are sampled one value per clock.

Top module: `line_latch_router`

## Requirements
- R1: After reset the latched codes are all zero, the latched polarity is low, and `drive_en` stays low until the first strobe pulse has been captured and the strobe has fallen.
- R2: In the first cycle that `strobe` is sampled high, the whole of `line_bus` is captured. Channel `i` holds bits `[6*i+5:6*i]`. The captured codes are visible on the outputs from the next cycle.
- R3: Between strobe rising edges the latched codes do not change, whatever `line_bus` does.
- R4: `drive_en` is low in every cycle in which `strobe` is high. Once a line has been captured, it is high in every cycle in which `strobe` is low.
- R5: `bank_sel` is 0 for the upper bank and 1 for the lower bank. Channels with an even index (odd-numbered outputs counting from 1) take the latched polarity as `bank_sel`, and channels with an odd index take its inverse.
- R6: Polarity is sampled in the same cycle as the line capture. Later changes of `polarity` have no effect until the next capture.
- R7: For the upper bank, the segment index is the code divided by 16 and the step is the code modulo 16. Segment k lies between upper taps k and k+1, and code 63 is step 15 of segment 3.
- R8: For the lower bank, the map is mirrored. The segment index is 3 minus the code divided by 16, and the step is the code modulo 16. Code 0 is segment 3 step 0, and code 63 is segment 0 step 15.
- R9: If the strobe falls after fewer than MIN_STB_W (default 2) cycles high, `proto_err` is high in the cycle after the fall.
- R10: If `load_en` is high in the strobe capture cycle or in any of the LOAD_GAP-1 (default 1) cycles before it, `proto_err` is high in the next cycle.
- R11: If `start_in` is high in the capture cycle or in any of the START_GAP-1 (default 1) cycles after it, `proto_err` is high in the next cycle.
- R12: `proto_err` is low in every cycle that does not follow one of the violations in R9 to R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_bus | input | 6*NCH | Captured line codes, channel i at bits 6i+5..6i |
| strobe | input | 1 | Line strobe: capture on rise, outputs released on fall |
| polarity | input | 1 | Bank polarity for the next captured line |
| load_en | input | 1 | High in cycles where display data is being clocked in |
| start_in | input | 1 | Start pulse of the next line transfer |
| bank_sel | output | NCH | Per-channel bank: 0 upper, 1 lower |
| seg_idx | output | 2*NCH | Per-channel ladder segment index |
| step_off | output | 4*NCH | Per-channel step within the segment |
| drive_en | output | NCH | Per-channel drive enable, low means high impedance |
| proto_err | output | 1 | One-cycle pulse on a strobe timing violation |

## Verification
The properties assume that `strobe`, `load_en` and `start_in` are sampled clean once per clock, and that `line_bus` is only meaningful in the capture cycle. Nothing is assumed about the protocol rules themselves: the monitor must flag their violations, not rely on them. The stimulus changes every input one time unit after the rising edge. Most lines keep the spacing rules, while a few are built on purpose with a one-cycle strobe, a late load or an early start. The bus and polarity are also altered in the middle of each line, so that R3 and R6 are tested by input that would be visible if it leaked through.

// File: rtl/lll_pkg.sv
package lll_pkg;
  localparam int CODE_W = 6;
  localparam int SEG_W  = 2;
  localparam int STEP_W = 4;

  typedef struct packed {
    logic              bank;
    logic [SEG_W-1:0]  seg;
    logic [STEP_W-1:0] step;
  } tap_t;

  // bank 0 = upper: segment counted from the top tap downward in code order.
  // bank 1 = lower: same step, segment mirrored so code 0 lands on the bottom tap.
  function automatic tap_t map_code(input logic [CODE_W-1:0] code, input logic bank);
    tap_t t;
    t.bank = bank;
    t.step = code[STEP_W-1:0];
    if (bank) t.seg = 2'd3 - code[CODE_W-1:STEP_W];
    else      t.seg = code[CODE_W-1:STEP_W];
    return t;
  endfunction

  // Channel parity picks which side of the polarity a channel takes.
  function automatic logic chan_bank(input int ch, input logic pol);
    return ((ch % 2) == 0) ? pol : ~pol;
  endfunction
endpackage

// File: rtl/lll_strobe_ctrl.sv
module lll_strobe_ctrl #(
  parameter int MIN_STB_W = 2,
  localparam int HW = $clog2(MIN_STB_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  output logic          rise_ev,
  output logic          fall_ev,
  output logic [HW-1:0] hi_cnt,
  output logic          drive_ok
);
  logic strb_q;
  logic armed_q;

  assign rise_ev  = strobe & ~strb_q;
  assign fall_ev  = ~strobe & strb_q;
  assign drive_ok = armed_q & ~strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q  <= 1'b0;
      armed_q <= 1'b0;
      hi_cnt  <= '0;
    end else begin
      strb_q <= strobe;
      if (rise_ev) armed_q <= 1'b1;
      if (!strobe)
        hi_cnt <= '0;
      else if (int'(hi_cnt) < MIN_STB_W)
        hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lll_line_store.sv
module lll_line_store
  import lll_pkg::*;
#(
  parameter int NCH = 16,
  localparam int BW = NCH * CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_ev,
  input  logic [BW-1:0] line_bus,
  input  logic          polarity,
  output logic [BW-1:0] lat_codes,
  output logic          lat_pol
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_codes <= '0;
      lat_pol   <= 1'b0;
    end else if (rise_ev) begin
      lat_codes <= line_bus;
      lat_pol   <= polarity;
    end
  end
endmodule

// File: rtl/lll_tap_map.sv
module lll_tap_map
  import lll_pkg::*;
#(
  parameter int NCH = 16,
  localparam int BW = NCH * CODE_W
) (
  input  logic                  drive_ok,
  input  logic [BW-1:0]         lat_codes,
  input  logic                  lat_pol,
  output logic [NCH-1:0]        bank_sel,
  output logic [SEG_W*NCH-1:0]  seg_idx,
  output logic [STEP_W*NCH-1:0] step_off,
  output logic [NCH-1:0]        drive_en
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tap_t tap;
    assign tap = map_code(lat_codes[ch*CODE_W +: CODE_W], chan_bank(ch, lat_pol));
    assign bank_sel[ch]                 = tap.bank;
    assign seg_idx[ch*SEG_W +: SEG_W]   = tap.seg;
    assign step_off[ch*STEP_W +: STEP_W] = tap.step;
    assign drive_en[ch]                 = drive_ok;
  end
endmodule

// File: rtl/lll_proto_mon.sv
module lll_proto_mon #(
  parameter int MIN_STB_W = 2,
  parameter int LOAD_GAP  = 2,
  parameter int START_GAP = 2,
  localparam int HW = $clog2(MIN_STB_W + 1),
  localparam int LW = $clog2(LOAD_GAP + 1),
  localparam int SW = $clog2(START_GAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_ev,
  input  logic          fall_ev,
  input  logic [HW-1:0] hi_cnt,
  input  logic          load_en,
  input  logic          start_in,
  output logic          any_viol,
  output logic          proto_err
);
  logic [LW-1:0] ld_cnt;
  logic [SW-1:0] rs_cnt;
  logic viol_w, viol_ld, viol_st;

  assign viol_w   = fall_ev && (int'(hi_cnt) < MIN_STB_W);
  assign viol_ld  = rise_ev && (load_en || (int'(ld_cnt) < LOAD_GAP - 1));
  assign viol_st  = start_in && (rise_ev || (int'(rs_cnt) < START_GAP - 1));
  assign any_viol = viol_w | viol_ld | viol_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cnt    <= LW'(LOAD_GAP);
      rs_cnt    <= SW'(START_GAP);
      proto_err <= 1'b0;
    end else begin
      proto_err <= any_viol;
      if (load_en)
        ld_cnt <= '0;
      else if (int'(ld_cnt) < LOAD_GAP)
        ld_cnt <= ld_cnt + 1'b1;
      if (rise_ev)
        rs_cnt <= '0;
      else if (int'(rs_cnt) < START_GAP)
        rs_cnt <= rs_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/line_latch_router.sv
module line_latch_router
  import lll_pkg::*;
#(
  parameter int NCH       = 16,
  parameter int MIN_STB_W = 2,
  parameter int LOAD_GAP  = 2,
  parameter int START_GAP = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH*CODE_W-1:0]     line_bus,
  input  logic                      strobe,
  input  logic                      polarity,
  input  logic                      load_en,
  input  logic                      start_in,
  output logic [NCH-1:0]            bank_sel,
  output logic [NCH*SEG_W-1:0]      seg_idx,
  output logic [NCH*STEP_W-1:0]     step_off,
  output logic [NCH-1:0]            drive_en,
  output logic                      proto_err
);
  localparam int HW = $clog2(MIN_STB_W + 1);
  localparam int BW = NCH * CODE_W;

  logic          rise_ev, fall_ev, drive_ok, any_viol, lat_pol;
  logic [HW-1:0] hi_cnt;
  logic [BW-1:0] lat_codes;

  lll_strobe_ctrl #(.MIN_STB_W(MIN_STB_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .hi_cnt(hi_cnt), .drive_ok(drive_ok)
  );

  lll_line_store #(.NCH(NCH)) u_store (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .line_bus(line_bus),
    .polarity(polarity), .lat_codes(lat_codes), .lat_pol(lat_pol)
  );

  lll_tap_map #(.NCH(NCH)) u_map (
    .drive_ok(drive_ok), .lat_codes(lat_codes), .lat_pol(lat_pol),
    .bank_sel(bank_sel), .seg_idx(seg_idx), .step_off(step_off), .drive_en(drive_en)
  );

  lll_proto_mon #(.MIN_STB_W(MIN_STB_W), .LOAD_GAP(LOAD_GAP), .START_GAP(START_GAP)) u_mon (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev), .hi_cnt(hi_cnt),
    .load_en(load_en), .start_in(start_in), .any_viol(any_viol), .proto_err(proto_err)
  );
endmodule

// File: rtl/line_latch_router_chk.sv
module line_latch_router_chk #(
  parameter int NCH       = 16,
  parameter int MIN_STB_W = 2,
  localparam int HW = $clog2(MIN_STB_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic              rise_ev,
  input logic              fall_ev,
  input logic [HW-1:0]     hi_cnt,
  input logic              any_viol,
  input logic [NCH*6-1:0]  line_bus,
  input logic [NCH*6-1:0]  lat_codes,
  input logic              lat_pol,
  input logic [NCH-1:0]    bank_sel,
  input logic [NCH-1:0]    drive_en,
  input logic              proto_err
);
  // R4: no channel drives while the strobe is high
  a_r4_hiz_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (drive_en == '0));

  // R2: the bus seen in the capture cycle is what the latch holds next
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> (lat_codes == $past(line_bus)));

  // R3 / R6: no capture means latch contents and polarity stay put
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ev |=> ($stable(lat_codes) && $stable(lat_pol)));

  // R5: neighbouring channels always on opposite banks
  if (NCH > 1) begin : g_pair
    a_r5_opposite: assert property (@(posedge clk) disable iff (!rst_n)
      bank_sel[0] != bank_sel[1]);
  end

  // R9: a short strobe is flagged the cycle after it falls
  a_r9_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && (int'(hi_cnt) < MIN_STB_W)) |=> proto_err);

  // R12: an error pulse only follows a detected violation
  a_r12_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(any_viol));
endmodule

bind line_latch_router line_latch_router_chk #(.NCH(NCH), .MIN_STB_W(MIN_STB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .rise_ev(rise_ev), .fall_ev(fall_ev),
  .hi_cnt(hi_cnt), .any_viol(any_viol), .line_bus(line_bus), .lat_codes(lat_codes),
  .lat_pol(lat_pol), .bank_sel(bank_sel), .drive_en(drive_en), .proto_err(proto_err)
);

// File: tb/line_latch_router_tb.sv
module line_latch_router_tb;
  localparam int PERIOD = 10;
  localparam int NCH    = 16;
  localparam int BW     = NCH * 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BW-1:0] line_bus = '0;
  logic strobe = 1'b0, polarity = 1'b0, load_en = 1'b0, start_in = 1'b0;
  logic [NCH-1:0] bank_sel, drive_en;
  logic [2*NCH-1:0] seg_idx;
  logic [4*NCH-1:0] step_off;
  logic proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  line_latch_router #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_bus(line_bus), .strobe(strobe), .polarity(polarity),
    .load_en(load_en), .start_in(start_in), .bank_sel(bank_sel), .seg_idx(seg_idx),
    .step_off(step_off), .drive_en(drive_en), .proto_err(proto_err)
  );

  always #(PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  int  ref_code[NCH];
  bit  ref_pol, ref_armed, ref_err, prev_strb;
  int  cyc, last_load, last_rise, hi_len;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ref_code[i]) ref_code[i] = 0;
      ref_pol = 0; ref_armed = 0; ref_err = 0; prev_strb = 0;
      cyc = 0; last_load = -100; last_rise = -100; hi_len = 0;
    end else begin
      bit rise, fall, bad;
      cyc++;
      rise = strobe && !prev_strb;
      fall = !strobe && prev_strb;
      bad = 0;
      if (fall && hi_len < 2) bad = 1;
      if (rise && (load_en || (cyc - last_load) < 2)) bad = 1;
      if (rise) last_rise = cyc;
      if (start_in && (cyc - last_rise) < 2) bad = 1;
      if (load_en) last_load = cyc;
      hi_len = strobe ? hi_len + 1 : 0;
      if (rise) begin
        for (int i = 0; i < NCH; i++) ref_code[i] = int'(line_bus[6*i +: 6]);
        ref_pol = polarity;
        ref_armed = 1;
      end
      ref_err = bad;
      prev_strb = strobe;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int out_code(input int ch);
    int s = int'(seg_idx[2*ch +: 2]);
    int t = int'(step_off[4*ch +: 4]);
    return bank_sel[ch] ? (3 - s) * 16 + t : s * 16 + t;
  endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++) begin
        int  eb;
        eb = (i % 2 == 0) ? int'(ref_pol) : int'(!ref_pol);
        check("R5 bank", int'(bank_sel[i]), eb);
        if (eb == 0) begin
          check("R7 seg", int'(seg_idx[2*i +: 2]), ref_code[i] / 16);
          check("R7 step", int'(step_off[4*i +: 4]), ref_code[i] % 16);
        end else begin
          check("R8 seg", int'(seg_idx[2*i +: 2]), 3 - ref_code[i] / 16);
          check("R8 step", int'(step_off[4*i +: 4]), ref_code[i] % 16);
        end
        check(ref_armed ? "R4 drive" : "R1 drive", int'(drive_en[i]),
              int'(ref_armed && !strobe));
      end
      check(ref_err ? "R9/R10/R11 err" : "R12 err", int'(proto_err), int'(ref_err));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // gap: cycles from load to capture; width: strobe high cycles; st: start offset
  task automatic do_line(input logic [BW-1:0] data, input logic pol,
                         input int gap, input int width, input int st);
    int last;
    line_bus = data; load_en = 1; tick();
    load_en = 0;
    repeat (gap - 1) tick();
    strobe = 1; polarity = pol; tick();
    line_bus = ~data; polarity = ~pol;
    last = (width > st ? width : st) + 2;
    for (int k = 1; k <= last; k++) begin
      strobe   = (k < width);
      start_in = (k == st);
      tick();
    end
    start_in = 0;
    @(negedge clk);
    for (int i = 0; i < NCH; i++)
      check("R2 R3 captured code", out_code(i), int'(data[6*i +: 6]));
    check("R6 polarity held", int'(bank_sel[0]), int'(pol));
    tick();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] d;
    repeat (4) tick();
    rst_n = 1;
    tick();
    @(negedge clk);
    check("R1 drive idle", int'(drive_en), 0);
    check("R1 ch0 code", out_code(0), 0);
    check("R1 ch1 bank", int'(bank_sel[1]), 1);
    check("R1 ch1 seg", int'(seg_idx[3:2]), 3);
    tick();

    // boundary codes in both banks
    for (int i = 0; i < NCH; i++) begin
      int bc[8] = '{0, 15, 16, 31, 32, 47, 48, 63};
      d[6*i +: 6] = 6'(bc[i % 8]);
    end
    do_line(d, 1'b0, 2, 2, 3);
    do_line(d, 1'b1, 3, 3, 4);
    // generic lines
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < NCH; i++) d[6*i +: 6] = 6'($urandom_range(0, 63));
      do_line(d, 1'(n % 2), 2 + n % 2, 2 + n % 3, 2 + n % 2);
    end
    // R9: one-cycle strobe
    for (int i = 0; i < NCH; i++) d[6*i +: 6] = 6'(i * 4);
    do_line(d, 1'b0, 2, 1, 3);
    // R10: load in the cycle just before capture
    do_line(~d, 1'b1, 1, 2, 3);
    // R11: start in the cycle after capture
    do_line(d, 1'b0, 2, 2, 1);
    do_line(~d, 1'b1, 2, 2, 2);
    repeat (3) tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule